// File: doc/BRIEF.md
# Ethernet Pause Transmit Flow Controller

This block drives the transmit half of Ethernet MAC flow control. In full-duplex operation a software request sets a busy flag and makes the block ask the frame builder for a pause frame carrying the configured pause time. The busy flag drops by itself once the builder reports the frame sent. While a separate hold request stays high, the block starts a slot-time timer at each completed pause frame. It asks for the next pause frame on its own once the timer reaches the pause time minus a threshold picked by a 2-bit code, so the link partner is refreshed before its pause expires.

In half-duplex operation the same busy flag instead enters a back-pressure state. Every frame start seen on the interface in that state produces a jam request, which signals a collision. Nothing happens unless the flow control enable is set. The block builds no frame bytes and no CRC, and it does no MII signalling. It only issues requests and follows their completion.

Top module: `pause_tx_flowctl`

## Requirements
- R1: After a synchronous reset, pause_req, busy, backpressure, jam_req, cfg_err and pause_quanta are all 0.
- R2: A slot time is BITS_PER_SLOT bit strobes (default 512). The slot timer advances only on cycles where bit_tick is high, so with strobes on alternate cycles a target of T slots takes 2*T*BITS_PER_SLOT cycles from pause_done to pause_req.
- R3: The threshold code selects 4, 28, 144 or 256 slot times for codes 0, 1, 2 and 3. The automatic resend point is the pause time minus that threshold: for example, pause time 128 with code 1 resends at 100 slots.
- R4: With hold_req high, the timer starts from zero at the pause_done that completes a frame. pause_req pulses one cycle after the slot count first reaches or passes the resend point. With a strobe every cycle, that is T*BITS_PER_SLOT+1 cycles after pause_done.
- R5: While the accepted enable is 0, ctl_set is ignored: busy, backpressure and pause_req stay 0.
- R6: In full duplex, ctl_set with busy low raises busy and a one-cycle pause_req in the next cycle. busy falls in the cycle after pause_done. ctl_set while busy is ignored.
- R7: In half duplex, ctl_set raises busy and backpressure. A frame_start seen while backpressure is high gives a one-cycle jam_req in the next cycle. frame_start has no effect in full duplex.
- R8: cfg_err is set by an accepted write whose pause time is less than or equal to the selected threshold. While it is set, a manual pause frame is still sent but no automatic resend follows.
- R9: A configuration write while busy is high is ignored: pause time, code, mode and flag keep their values. The one exception is an enable of 0 written during back-pressure.
- R10: Back-pressure, and busy with it, ends in the cycle after ctl_clr or after a configuration write with cfg_fc_en at 0. In full duplex, ctl_clr has no effect.
- R11: If hold_req is low at pause_done or during the timed wait, the timer stops and no further pause_req is issued until the next ctl_set.
- R12: pause_quanta holds the accepted pause time captured at each pause_req, manual or automatic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One strobe per transmitted bit time |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fc_en | input | 1 | Transmit flow control enable |
| cfg_full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| cfg_thresh_code | input | 2 | Resend threshold code (0:4, 1:28, 2:144, 3:256 slots) |
| cfg_pause_time | input | PT_W | Pause time in slot times |
| ctl_set | input | 1 | Software sets the busy flag (pulse) |
| ctl_clr | input | 1 | Software clears the busy flag, ending back-pressure (pulse) |
| hold_req | input | 1 | Keep resending pause frames while high |
| pause_done | input | 1 | Frame builder reports the pause frame sent (pulse) |
| frame_start | input | 1 | A frame is starting on the interface (pulse) |
| pause_req | output | 1 | Request one pause frame (one-cycle pulse) |
| pause_quanta | output | PT_W | Pause time to place in the requested frame |
| busy | output | 1 | Busy flag (full duplex frame in flight, or back-pressure) |
| backpressure | output | 1 | Half-duplex back-pressure active |
| jam_req | output | 1 | Request a jam pattern (one-cycle pulse) |
| cfg_err | output | 1 | Threshold not below the accepted pause time |

## Verification
Every result lands exactly one clock after the edge that samples its cause. That holds for pause_req and busy after ctl_set, for busy after pause_done, for jam_req after frame_start, and for cfg_err and the frozen fields after a configuration write. The automatic resend is due T*BITS_PER_SLOT+1 clocks after pause_done with a strobe every cycle, and 2*T*BITS_PER_SLOT clocks with strobes on alternate cycles. Inputs change one nanosecond after a rising edge and outputs are read on the falling edge. A behavioural model advances on the same edges and is compared on every clock. Directed checks count the clocks from pause_done to the resend pulse, so a timer that is early or late by one clock is reported.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Controller states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,   // no full-duplex frame pending, no timer running
    ST_WAIT   = 2'd1,   // pause frame requested, waiting for completion
    ST_TIMING = 2'd2    // counting slots towards the next automatic resend
  } pfc_state_e;

  localparam int THR_W = 9;

  // Slot-time distance before expiry at which the next pause is sent (R3)
  function automatic logic [THR_W-1:0] thr_slots(input logic [1:0] code);
    logic [THR_W-1:0] r;
    case (code)
      2'd0:    r = THR_W'(4);
      2'd1:    r = THR_W'(28);
      2'd2:    r = THR_W'(144);
      default: r = THR_W'(256);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfc_cfg_regs.sv
module pfc_cfg_regs #(
  parameter int PT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            wr_en,
  input  logic            wr_fd,
  input  logic [1:0]      wr_code,
  input  logic [PT_W-1:0] wr_ptime,
  input  logic            busy,
  output logic            en_q,
  output logic            fd_q,
  output logic [1:0]      code_q,
  output logic [PT_W-1:0] ptime_q,
  output logic            err_q,
  output logic            bp_stop
);
  import pfc_pkg::*;

  localparam int CW = ((PT_W > THR_W) ? PT_W : THR_W) + 1;

  logic          accept;
  logic [CW-1:0] pt_x;
  logic [CW-1:0] thr_x;
  logic          wr_bad;

  // Writes are taken only while no frame or back-pressure is in progress (R9)
  assign accept  = wr && !busy;
  // Disabling flow control during back-pressure is still honoured (R10)
  assign bp_stop = wr && busy && !fd_q && !wr_en;

  assign pt_x   = CW'(wr_ptime);
  assign thr_x  = CW'(thr_slots(wr_code));
  assign wr_bad = (pt_x <= thr_x);   // threshold must be below the pause time (R8)

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      fd_q    <= 1'b0;
      code_q  <= 2'd0;
      ptime_q <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      en_q    <= wr_en;
      fd_q    <= wr_fd;
      code_q  <= wr_code;
      ptime_q <= wr_ptime;
      err_q   <= wr_bad;
    end else if (bp_stop) begin
      en_q    <= 1'b0;
    end
  end

endmodule

// File: rtl/pfc_slot_timer.sv
module pfc_slot_timer #(
  parameter int BITS_PER_SLOT = 512,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             bit_tick,
  output logic [CNT_W-1:0] slots
);
  localparam int PRESC_W = (BITS_PER_SLOT > 1) ? $clog2(BITS_PER_SLOT) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(BITS_PER_SLOT - 1);
  localparam logic [CNT_W-1:0]   CNT_MAX    = {CNT_W{1'b1}};

  logic slot_tick;

  generate
    if (BITS_PER_SLOT > 1) begin : g_presc
      logic [PRESC_W-1:0] presc;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          presc <= '0;
        end else if (run && bit_tick) begin
          if (presc == PRESC_LAST) presc <= '0;
          else                     presc <= presc + 1'b1;
        end
      end
      assign slot_tick = run && bit_tick && (presc == PRESC_LAST);
    end else begin : g_direct
      assign slot_tick = run && bit_tick;
    end
  endgenerate

  // Slot counter, saturating at its top value
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      slots <= '0;
    end else if (slot_tick && (slots != CNT_MAX)) begin
      slots <= slots + 1'b1;
    end
  end

endmodule

// File: rtl/pfc_tx_ctrl.sv
module pfc_tx_ctrl #(
  parameter int PT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            fd,
  input  logic [1:0]      code,
  input  logic [PT_W-1:0] ptime,
  input  logic            err,
  input  logic            bp_stop,
  input  logic            ctl_set,
  input  logic            ctl_clr,
  input  logic            hold,
  input  logic            done,
  input  logic            frame_start,
  input  logic [PT_W-1:0] slots,
  output logic            tmr_clr,
  output logic            tmr_run,
  output logic            busy,
  output logic            bp,
  output logic            req,
  output logic            jam,
  output logic [PT_W-1:0] pq
);
  import pfc_pkg::*;

  localparam int CW = ((PT_W > THR_W) ? PT_W : THR_W) + 1;

  pfc_state_e    state;
  logic [CW-1:0] target;
  logic          reached;
  logic          keep_timing;

  // Resend point: pause time minus selected threshold (R3)
  assign target      = CW'(ptime) - CW'(thr_slots(code));
  assign reached     = (CW'(slots) >= target);
  assign keep_timing = hold && en && fd && !err;

  assign tmr_run = (state == ST_TIMING);
  assign tmr_clr = (state == ST_WAIT) && done && hold && !err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      bp    <= 1'b0;
      req   <= 1'b0;
      jam   <= 1'b0;
      pq    <= '0;
    end else begin
      req <= 1'b0;
      jam <= 1'b0;
      if (bp && frame_start) jam <= 1'b1;            // R7

      if (state == ST_WAIT) begin
        if (done) begin                              // R6
          busy  <= 1'b0;
          state <= (hold && !err) ? ST_TIMING : ST_IDLE;
        end
      end else if (busy) begin                       // half-duplex back-pressure
        if (ctl_clr || bp_stop) begin                // R10
          busy <= 1'b0;
          bp   <= 1'b0;
        end
      end else if (ctl_set && en) begin
        busy <= 1'b1;
        if (fd) begin
          req   <= 1'b1;
          pq    <= ptime;
          state <= ST_WAIT;
        end else begin
          bp    <= 1'b1;
          state <= ST_IDLE;
        end
      end else if (state == ST_TIMING) begin
        if (!keep_timing) begin                      // R11
          state <= ST_IDLE;
        end else if (reached) begin                  // R4
          req   <= 1'b1;
          pq    <= ptime;
          busy  <= 1'b1;
          state <= ST_WAIT;
        end
      end
    end
  end

endmodule

// File: rtl/pause_tx_flowctl.sv
module pause_tx_flowctl #(
  parameter int PT_W          = 16,
  parameter int BITS_PER_SLOT = 512
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_tick,
  input  logic            cfg_we,
  input  logic            cfg_fc_en,
  input  logic            cfg_full_duplex,
  input  logic [1:0]      cfg_thresh_code,
  input  logic [PT_W-1:0] cfg_pause_time,
  input  logic            ctl_set,
  input  logic            ctl_clr,
  input  logic            hold_req,
  input  logic            pause_done,
  input  logic            frame_start,
  output logic            pause_req,
  output logic [PT_W-1:0] pause_quanta,
  output logic            busy,
  output logic            backpressure,
  output logic            jam_req,
  output logic            cfg_err
);

  logic            en_q;
  logic            fd_q;
  logic [1:0]      code_q;
  logic [PT_W-1:0] ptime_q;
  logic            err_q;
  logic            bp_stop;
  logic            tmr_clr;
  logic            tmr_run;
  logic [PT_W-1:0] slots;

  pfc_cfg_regs #(.PT_W(PT_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_we),
    .wr_en    (cfg_fc_en),
    .wr_fd    (cfg_full_duplex),
    .wr_code  (cfg_thresh_code),
    .wr_ptime (cfg_pause_time),
    .busy     (busy),
    .en_q     (en_q),
    .fd_q     (fd_q),
    .code_q   (code_q),
    .ptime_q  (ptime_q),
    .err_q    (err_q),
    .bp_stop  (bp_stop)
  );

  pfc_slot_timer #(.BITS_PER_SLOT(BITS_PER_SLOT), .CNT_W(PT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr      (tmr_clr),
    .run      (tmr_run),
    .bit_tick (bit_tick),
    .slots    (slots)
  );

  pfc_tx_ctrl #(.PT_W(PT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en          (en_q),
    .fd          (fd_q),
    .code        (code_q),
    .ptime       (ptime_q),
    .err         (err_q),
    .bp_stop     (bp_stop),
    .ctl_set     (ctl_set),
    .ctl_clr     (ctl_clr),
    .hold        (hold_req),
    .done        (pause_done),
    .frame_start (frame_start),
    .slots       (slots),
    .tmr_clr     (tmr_clr),
    .tmr_run     (tmr_run),
    .busy        (busy),
    .bp          (backpressure),
    .req         (pause_req),
    .jam         (jam_req),
    .pq          (pause_quanta)
  );

  assign cfg_err = err_q;

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int PT_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            pause_req,
  input logic            busy,
  input logic            backpressure,
  input logic            jam_req,
  input logic            hold_req,
  input logic            ctl_set,
  input logic            fc_en,
  input logic            fd,
  input logic [PT_W-1:0] ptime
);

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!pause_req && !busy && !backpressure && !jam_req));

  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    pause_req |=> !pause_req);

  a_r6_req_busy: assert property (@(posedge clk) disable iff (rst)
    pause_req |-> busy);

  a_r7_jam_source: assert property (@(posedge clk) disable iff (rst)
    jam_req |-> $past(backpressure));

  a_r7_bp_half_duplex: assert property (@(posedge clk) disable iff (rst)
    backpressure |-> (busy && !fd));

  a_r5_inert: assert property (@(posedge clk) disable iff (rst)
    !fc_en |=> (!pause_req && !backpressure));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(ptime));

  a_r11_no_hold: assert property (@(posedge clk) disable iff (rst)
    (!hold_req && !ctl_set) |=> !pause_req);

endmodule

bind pause_tx_flowctl pfc_checker #(.PT_W(PT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pause_req    (pause_req),
  .busy         (busy),
  .backpressure (backpressure),
  .jam_req      (jam_req),
  .hold_req     (hold_req),
  .ctl_set      (ctl_set),
  .fc_en        (en_q),
  .fd           (fd_q),
  .ptime        (ptime_q)
);

// File: tb/sim_pause_tx_flowctl.sv
`timescale 1ns/1ps
module sim_pause_tx_flowctl;
  localparam int PT_W = 16;
  localparam int BPS  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic            rst = 1'b1;
  logic            bit_tick = 1'b1;
  logic            cfg_we = 1'b0, cfg_fc_en = 1'b0, cfg_full_duplex = 1'b0;
  logic [1:0]      cfg_thresh_code = 2'd0;
  logic [PT_W-1:0] cfg_pause_time = '0;
  logic            ctl_set = 1'b0, ctl_clr = 1'b0, hold_req = 1'b0;
  logic            pause_done = 1'b0, frame_start = 1'b0;
  logic            pause_req, busy, backpressure, jam_req, cfg_err;
  logic [PT_W-1:0] pause_quanta;

  pause_tx_flowctl #(.PT_W(PT_W), .BITS_PER_SLOT(BPS)) u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .cfg_we(cfg_we),
    .cfg_fc_en(cfg_fc_en), .cfg_full_duplex(cfg_full_duplex),
    .cfg_thresh_code(cfg_thresh_code), .cfg_pause_time(cfg_pause_time),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .hold_req(hold_req),
    .pause_done(pause_done), .frame_start(frame_start),
    .pause_req(pause_req), .pause_quanta(pause_quanta), .busy(busy),
    .backpressure(backpressure), .jam_req(jam_req), .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;
  int req_seen = 0;
  bit finished = 1'b0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int thr(input int c);
    case (c)
      0: return 4;
      1: return 28;
      2: return 144;
      default: return 256;
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_state, m_busy, m_bp, m_req, m_jam, m_pq, m_err;
  int m_en, m_fd, m_code, m_pt, m_presc, m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_state <= 0; m_busy <= 0; m_bp <= 0; m_req <= 0; m_jam <= 0;
      m_pq <= 0; m_err <= 0; m_en <= 0; m_fd <= 0; m_code <= 0;
      m_pt <= 0; m_presc <= 0; m_cnt <= 0;
    end else begin
      m_req <= 0;
      m_jam <= 0;
      if (frame_start && m_bp != 0) m_jam <= 1;
      if (cfg_we) begin
        if (m_busy == 0) begin
          m_en <= cfg_fc_en; m_fd <= cfg_full_duplex;
          m_code <= cfg_thresh_code; m_pt <= cfg_pause_time;
          m_err <= (int'(cfg_pause_time) <= thr(cfg_thresh_code)) ? 1 : 0;
        end else if (m_fd == 0 && !cfg_fc_en) begin
          m_en <= 0;
        end
      end
      if (m_state == 1) begin
        if (pause_done) begin
          m_busy <= 0;
          if (hold_req && m_err == 0) begin
            m_state <= 2; m_presc <= 0; m_cnt <= 0;
          end else m_state <= 0;
        end
      end else if (m_busy != 0) begin
        if (ctl_clr || (cfg_we && !cfg_fc_en)) begin m_busy <= 0; m_bp <= 0; end
      end else if (ctl_set && m_en != 0) begin
        m_busy <= 1;
        if (m_fd != 0) begin m_req <= 1; m_pq <= m_pt; m_state <= 1; end
        else begin m_bp <= 1; m_state <= 0; end
      end else if (m_state == 2) begin
        if (!hold_req || m_en == 0 || m_fd == 0 || m_err != 0) m_state <= 0;
        else if (m_cnt >= m_pt - thr(m_code)) begin
          m_req <= 1; m_pq <= m_pt; m_busy <= 1; m_state <= 1;
        end
      end
      if (m_state == 2 && bit_tick) begin
        if (m_presc == BPS - 1) begin m_presc <= 0; m_cnt <= m_cnt + 1; end
        else m_presc <= m_presc + 1;
      end
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(int'(pause_req),    m_req,  "R6 model pause_req");
      chk(int'(busy),         m_busy, "R6 model busy");
      chk(int'(backpressure), m_bp,   "R7 model backpressure");
      chk(int'(jam_req),      m_jam,  "R7 model jam_req");
      chk(int'(cfg_err),      m_err,  "R8 model cfg_err");
      chk(int'(pause_quanta), m_pq,   "R12 model pause_quanta");
      if (pause_req) req_seen++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_cfg(input bit en, input bit fd, input int code, input int pt);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_fc_en = en; cfg_full_duplex = fd;
    cfg_thresh_code = 2'(code); cfg_pause_time = PT_W'(pt);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_set();
    @(posedge clk); #1 ctl_set = 1'b1;
    @(posedge clk); #1 ctl_set = 1'b0;
  endtask

  task automatic do_clr();
    @(posedge clk); #1 ctl_clr = 1'b1;
    @(posedge clk); #1 ctl_clr = 1'b0;
  endtask

  task automatic do_done();
    @(posedge clk); #1 pause_done = 1'b1;
    @(posedge clk); #1 pause_done = 1'b0;
  endtask

  task automatic do_frame();
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Cycles from the pause_done edge to the first pause_req
  task automatic measure(output int n, input bit alt);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      n++;
      #1 if (alt) bit_tick = ~bit_tick;
      @(negedge clk);
      if (pause_req) break;
    end
    bit_tick = 1'b1;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    int seen0;
    idle(4);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk(int'(pause_req), 0, "R1 pause_req");
    chk(int'(busy), 0, "R1 busy");
    chk(int'(backpressure), 0, "R1 backpressure");
    chk(int'(jam_req), 0, "R1 jam_req");
    chk(int'(cfg_err), 0, "R1 cfg_err");
    chk(int'(pause_quanta), 0, "R1 pause_quanta");

    // R5: disabled block ignores requests
    do_cfg(0, 1, 0, 40);
    do_set();
    @(negedge clk);
    chk(int'(pause_req), 0, "R5 no pause when disabled");
    chk(int'(busy), 0, "R5 busy stays low");
    do_cfg(0, 0, 0, 40);
    do_set();
    do_frame();
    @(negedge clk);
    chk(int'(backpressure), 0, "R5 no backpressure when disabled");

    // R6: manual pause frame, busy tracks completion
    do_cfg(1, 1, 0, 40);
    hold_req = 1'b0;
    do_set();
    @(negedge clk);
    chk(int'(pause_req), 1, "R6 pause_req one cycle after set");
    chk(int'(busy), 1, "R6 busy set");
    chk(int'(pause_quanta), 40, "R12 quanta on manual pause");
    @(negedge clk);
    chk(int'(pause_req), 0, "R6 pause_req single cycle");
    do_set();       // ignored while busy
    do_frame();     // ignored in full duplex
    @(negedge clk);
    chk(int'(jam_req), 0, "R7 no jam in full duplex");
    do_done();
    @(negedge clk);
    chk(int'(busy), 0, "R6 busy clears after done");
    seen0 = req_seen;
    idle(400);
    chk(req_seen - seen0, 0, "R11 no resend without hold");

    // R4 / R9 / R12: automatic resend, code 0, pause 40 -> 36 slots
    hold_req = 1'b1;
    do_set();
    do_done();
    measure(n, 1'b0);
    chk(n, 36*BPS + 1, "R4 resend delay code0");
    do_cfg(1, 1, 1, 99);          // ignored: busy
    chk(int'(cfg_err), 0, "R9 flag unchanged by busy write");
    do_done();
    measure(n, 1'b0);
    chk(n, 36*BPS + 1, "R9 timing unchanged by busy write");
    chk(int'(pause_quanta), 40, "R9 R12 quanta unchanged");
    do_done();
    idle(50);
    hold_req = 1'b0;
    seen0 = req_seen;
    idle(400);
    chk(req_seen - seen0, 0, "R11 hold dropped stops resend");

    // R3: pause 128 code 1 -> 100 slots
    do_cfg(1, 1, 1, 128);
    hold_req = 1'b1;
    do_set();
    do_done();
    measure(n, 1'b0);
    chk(n, 100*BPS + 1, "R3 code1 resend at 100 slots");
    chk(int'(pause_quanta), 128, "R12 quanta on auto pause");
    hold_req = 1'b0;
    do_done();

    // R3: code 2 (pause 200 -> 56) and code 3 (pause 300 -> 44)
    do_cfg(1, 1, 2, 200);
    hold_req = 1'b1;
    do_set();
    do_done();
    measure(n, 1'b0);
    chk(n, 56*BPS + 1, "R3 code2 resend at 56 slots");
    hold_req = 1'b0;
    do_done();
    do_cfg(1, 1, 3, 300);
    hold_req = 1'b1;
    do_set();
    do_done();
    measure(n, 1'b0);
    chk(n, 44*BPS + 1, "R3 code3 resend at 44 slots");
    hold_req = 1'b0;
    do_done();

    // R2: strobes on alternate cycles, pause 12 code 0 -> 8 slots
    do_cfg(1, 1, 0, 12);
    hold_req = 1'b1;
    do_set();
    do_done();
    measure(n, 1'b1);
    chk(n, 2*8*BPS, "R2 slot counts strobes not cycles");
    hold_req = 1'b0;
    do_done();

    // R8: invalid threshold
    do_cfg(1, 1, 0, 4);
    @(negedge clk);
    chk(int'(cfg_err), 1, "R8 equal threshold flagged");
    do_cfg(1, 1, 1, 20);
    @(negedge clk);
    chk(int'(cfg_err), 1, "R8 threshold above pause flagged");
    hold_req = 1'b1;
    do_set();
    @(negedge clk);
    chk(int'(pause_req), 1, "R8 manual pause still sent");
    do_done();
    seen0 = req_seen;
    idle(500);
    chk(req_seen - seen0, 0, "R8 no auto resend when flagged");
    do_cfg(1, 1, 0, 5);
    @(negedge clk);
    chk(int'(cfg_err), 0, "R8 pause 5 code0 valid");
    do_set();
    do_done();
    measure(n, 1'b0);
    chk(n, 1*BPS + 1, "R8 minimum target one slot");
    hold_req = 1'b0;
    do_done();

    // R7 / R10: half-duplex back-pressure
    do_cfg(1, 0, 0, 40);
    do_set();
    @(negedge clk);
    chk(int'(backpressure), 1, "R7 backpressure entered");
    chk(int'(busy), 1, "R7 busy in backpressure");
    chk(int'(pause_req), 0, "R7 no pause in half duplex");
    do_frame();
    @(negedge clk);
    chk(int'(jam_req), 1, "R7 jam after frame start");
    @(negedge clk);
    chk(int'(jam_req), 0, "R7 jam single cycle");
    do_clr();
    @(negedge clk);
    chk(int'(backpressure), 0, "R10 clear ends backpressure");
    do_frame();
    @(negedge clk);
    chk(int'(jam_req), 0, "R10 no jam after clear");
    do_set();
    do_cfg(0, 0, 3, 7);
    @(negedge clk);
    chk(int'(backpressure), 0, "R10 disable ends backpressure");
    chk(int'(cfg_err), 0, "R9 other fields ignored while busy");
    do_frame();
    @(negedge clk);
    chk(int'(jam_req), 0, "R10 no jam after disable");
    do_set();
    @(negedge clk);
    chk(int'(busy), 0, "R5 set ignored after disable");

    // R10: clear has no effect in full duplex
    do_cfg(1, 1, 0, 40);
    do_set();
    do_clr();
    @(negedge clk);
    chk(int'(busy), 1, "R10 clear ignored in full duplex");
    do_done();
    idle(5);

    finish_run();
  end

endmodule